// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the instruction fetch front end of a small accumulator machine whose memory words each carry two instructions. It keeps a program counter that counts instruction pairs. It copies that counter into an address register to read one word from a synchronous memory, and it captures the returned word in a buffer register. It then splits the word into a left and a right instruction.

The left instruction issues at once. The right instruction waits in an instruction buffer and issues later with no second memory read. Each issue presents an 8-bit opcode and a 12-bit operand address to the execute stage, using a valid/ready handshake. The execute stage can redirect the stream with a jump. A jump names a target word and chooses whether execution resumes at its left or its right half. A fetch from beyond the end of memory raises a sticky error flag and is not performed.

Top module: `pair_fetch_seq`

## Requirements
- R1: After reset `iss_valid`, `fetch_err` and `mem_rd_en` are 0 and the pair counter is 0, so the first issue is the left instruction of word 0.
- R2: A 40-bit word holds the left instruction in bits 39:20 and the right instruction in bits 19:0. In each instruction the opcode is the top 8 bits and the operand address is the low 12 bits. From a freshly read word the left instruction issues before the right one.
- R3: The right instruction of a word issues from the instruction buffer with no memory read. The memory is read only while the buffer is empty.
- R4: The pair counter advances by one only when a right instruction issues. Without jumps the issue order is left(p), right(p), left(p+1), right(p+1).
- R5: A read drives `mem_rd_en` high for one cycle with `mem_addr` equal to the pair counter. The word is taken from `mem_rdata` on the following clock edge.
- R6: While `iss_valid` is 1 and `iss_ready` is 0, and no jump is requested, `iss_valid`, `iss_opcode` and `iss_addr` keep their values.
- R7: A jump with `jmp_right` = 0 loads `jmp_target` into the pair counter and discards any buffered right instruction. The next issue is left(target).
- R8: A jump with `jmp_right` = 1 makes the next issue right(target), and then left(target+1). Word target is read exactly once for these two issues.
- R9: When a fetch is needed and the pair counter is at or above `MEM_WORDS`, `fetch_err` rises and no read or issue takes place. `fetch_err` stays 1 until reset, and a later jump back into range resumes fetching.
- R10: A jump clears a pending, unaccepted issue, so `iss_valid` is 0 in the cycle after the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Read address (address register) |
| mem_rdata | input | 40 | Word returned one cycle after the strobe |
| iss_valid | output | 1 | An instruction is offered to execute |
| iss_ready | input | 1 | Execute accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Operand address of the offered instruction |
| jmp_req | input | 1 | Redirect request, one cycle |
| jmp_target | input | 12 | Word address to resume at |
| jmp_right | input | 1 | 1: resume at the right half of the target word |
| fetch_err | output | 1 | Sticky out-of-range fetch flag |

## Verification
The bench builds the block with the default `MEM_WORDS` of 1000, so the memory ends at word 999. A jump to word 999 reaches the end of memory within a handful of cycles. After it, the issue of right(999) and the fetch of word 1000 that follows exercise the out-of-range path without running through the whole memory. Each memory word is a computed function of its address, with different opcodes and addresses in its two halves. A swapped half, a misplaced field or an off-by-one counter therefore shows up as a wrong issued value.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int OP_W    = 8;
    localparam int ADDR_W  = 12;
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int HALVES  = 2;
    localparam int WORD_W  = HALVES * INSTR_W;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_READ  = 2'd1,
        ST_CAPT  = 2'd2,
        ST_ISSUE = 2'd3
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mbr;
        instr_t            ibr;
        logic              ibr_vld;
        logic              resume_right;
        logic [OP_W-1:0]   ir;
        logic [ADDR_W-1:0] opaddr;
        logic              ovld;
        logic              err;
    } seq_t;
endpackage

// File: rtl/pfs_split.sv
module pfs_split
    import pfs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            left_i,
    output instr_t            right_i
);
    instr_t half [HALVES];

    // half[0] is the low slice (right), half[1] the high slice (left)
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half[h] = word[h*INSTR_W +: INSTR_W];
    end

    assign right_i = half[0];
    assign left_i  = half[HALVES-1];
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
    import pfs_pkg::*;
#(
    parameter int MEM_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mbr,
    input  instr_t            left_i,
    input  instr_t            right_i,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_opcode,
    output logic [ADDR_W-1:0] iss_addr,
    input  logic              jmp_req,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              jmp_right,
    output logic              fetch_err
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_WORDS);

    seq_t q, d;
    logic slot_free;

    always_comb begin
        d         = q;
        slot_free = !q.ovld || iss_ready;
        if (q.ovld && iss_ready) begin
            d.ovld = 1'b0;
        end
        unique case (q.st)
            ST_RUN: begin
                if (q.ibr_vld) begin
                    if (slot_free) begin
                        d.ir      = q.ibr.op;
                        d.opaddr  = q.ibr.addr;
                        d.ovld    = 1'b1;
                        d.ibr_vld = 1'b0;
                        d.pc      = q.pc + 1'b1;
                    end
                end else if (q.pc >= LIMIT) begin
                    d.err = 1'b1;
                end else begin
                    d.mar = q.pc;
                    d.st  = ST_READ;
                end
            end
            ST_READ: begin
                d.st = ST_CAPT;
            end
            ST_CAPT: begin
                d.mbr = mem_rdata;
                d.st  = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (slot_free) begin
                    d.ovld = 1'b1;
                    d.st   = ST_RUN;
                    if (q.resume_right) begin
                        d.ir           = right_i.op;
                        d.opaddr       = right_i.addr;
                        d.pc           = q.pc + 1'b1;
                        d.resume_right = 1'b0;
                    end else begin
                        d.ir      = left_i.op;
                        d.opaddr  = left_i.addr;
                        d.ibr     = right_i;
                        d.ibr_vld = 1'b1;
                    end
                end
            end
            default: d.st = ST_RUN;
        endcase
        if (jmp_req) begin
            d.pc           = jmp_target;
            d.ibr_vld      = 1'b0;
            d.resume_right = jmp_right;
            d.ovld         = 1'b0;
            d.st           = ST_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, ibr: '0, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en  = (q.st == ST_READ);
    assign mem_addr   = q.mar;
    assign mbr        = q.mbr;
    assign iss_valid  = q.ovld;
    assign iss_opcode = q.ir;
    assign iss_addr   = q.opaddr;
    assign fetch_err  = q.err;

    // R6: an offered instruction is held until accepted
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !jmp_req) |=>
            (iss_valid && $stable(iss_opcode) && $stable(iss_addr)));

    // R9: never read past the end of memory
    a_r9_no_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr < LIMIT));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |=> fetch_err);

    // R10: a jump drops a pending issue
    a_r10_jump_flush: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_req |=> !iss_valid);

    // R3: memory is read only while the instruction buffer is empty
    a_r3_read_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !q.ibr_vld);
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq
    import pfs_pkg::*;
#(
    parameter int MEM_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_opcode,
    output logic [ADDR_W-1:0] iss_addr,
    input  logic              jmp_req,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              jmp_right,
    output logic              fetch_err
);
    logic [WORD_W-1:0] mbr;
    instr_t            left_i;
    instr_t            right_i;

    pfs_split u_split (
        .word    (mbr),
        .left_i  (left_i),
        .right_i (right_i)
    );

    pfs_seq #(.MEM_WORDS(MEM_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mbr        (mbr),
        .left_i     (left_i),
        .right_i    (right_i),
        .iss_valid  (iss_valid),
        .iss_ready  (iss_ready),
        .iss_opcode (iss_opcode),
        .iss_addr   (iss_addr),
        .jmp_req    (jmp_req),
        .jmp_target (jmp_target),
        .jmp_right  (jmp_right),
        .fetch_err  (fetch_err)
    );
endmodule

// File: tb/tb_pair_fetch_seq.sv
`timescale 1ns/1ps
module tb_pair_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [39:0] mem_rdata = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [7:0]  iss_opcode;
    logic [11:0] iss_addr;
    logic        jmp_req = 1'b0;
    logic [11:0] jmp_target = '0;
    logic        jmp_right = 1'b0;
    logic        fetch_err;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    logic [11:0] last_rd = '0;
    bit oob_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pair_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_opcode(iss_opcode), .iss_addr(iss_addr), .jmp_req(jmp_req),
        .jmp_target(jmp_target), .jmp_right(jmp_right), .fetch_err(fetch_err)
    );

    // R2 layout: left op [39:32], left addr [31:20], right op [19:12], right addr [11:0]
    function automatic logic [7:0]  lop(int a);  return 8'(a*3 + 1);    endfunction
    function automatic logic [11:0] ladr(int a); return 12'(a + 100);   endfunction
    function automatic logic [7:0]  rop(int a);  return 8'(a*7 + 2);    endfunction
    function automatic logic [11:0] radr(int a); return 12'(a + 200);   endfunction

    // memory model: one-cycle read latency (R5)
    always @(posedge clk) begin
        if (rst_n && mem_rd_en) begin
            mem_rdata <= {lop(int'(mem_addr)), ladr(int'(mem_addr)),
                          rop(int'(mem_addr)), radr(int'(mem_addr))};
            rd_cnt    <= rd_cnt + 1;
            last_rd   <= mem_addr;
            if (mem_addr >= 12'd1000) oob_seen <= 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic expect_issue(input logic [7:0] eop, input logic [11:0] eadr, input string tag);
        int w = 0;
        while (!iss_valid && w < 200) begin
            @(negedge clk);
            w++;
        end
        chk(iss_valid == 1'b1, tag, $sformatf("valid actual=%0b expected=1", iss_valid));
        if (iss_valid) begin
            chk(iss_opcode == eop && iss_addr == eadr, tag,
                $sformatf("op/addr actual=%h/%0d expected=%h/%0d", iss_opcode, iss_addr, eop, eadr));
        end
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
    endtask

    task automatic do_jump(input int tgt, input bit right);
        jmp_req = 1'b1; jmp_target = 12'(tgt); jmp_right = right;
        @(negedge clk);
        jmp_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(iss_valid == 0, "R1", $sformatf("iss_valid actual=%0b expected=0", iss_valid));
        chk(fetch_err == 0, "R1", $sformatf("fetch_err actual=%0b expected=0", fetch_err));
        chk(mem_rd_en == 0, "R1", $sformatf("mem_rd_en actual=%0b expected=0", mem_rd_en));
        rst_n = 1'b1;
    endtask

    task automatic t_sequential();
        int c;
        for (int p = 0; p < 3; p++) begin
            expect_issue(lop(p), ladr(p), "R2 R4 left");
            chk(last_rd == 12'(p), "R5", $sformatf("read addr actual=%0d expected=%0d", last_rd, p));
            c = rd_cnt;
            expect_issue(rop(p), radr(p), "R2 R4 right");
            chk(rd_cnt == c, "R3", $sformatf("reads for right actual=%0d expected=%0d", rd_cnt - c, 0));
        end
    endtask

    task automatic t_stall();
        logic [7:0] op0; logic [11:0] ad0; int w = 0;
        while (!iss_valid && w < 200) begin @(negedge clk); w++; end
        op0 = iss_opcode; ad0 = iss_addr;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(iss_valid && iss_opcode == op0 && iss_addr == ad0, "R6",
                $sformatf("held actual=%0b/%h/%0d expected=1/%h/%0d", iss_valid, iss_opcode, iss_addr, op0, ad0));
        end
        expect_issue(lop(3), ladr(3), "R6 accept");
    endtask

    task automatic t_jump_left_flush();
        int w = 0;
        do_jump(10, 0);
        while (!iss_valid && w < 200) begin @(negedge clk); w++; end
        chk(iss_valid && iss_opcode == lop(10), "R7",
            $sformatf("op actual=%h expected=%h", iss_opcode, lop(10)));
        do_jump(20, 0);
        chk(iss_valid == 0, "R10", $sformatf("iss_valid after jump actual=%0b expected=0", iss_valid));
        expect_issue(lop(20), ladr(20), "R7 left target");
        do_jump(30, 0);
        expect_issue(lop(30), ladr(30), "R7 buffered right discarded");
        expect_issue(rop(30), radr(30), "R7 follow-on");
    endtask

    task automatic t_jump_right();
        int c;
        do_jump(50, 1);
        c = rd_cnt;
        expect_issue(rop(50), radr(50), "R8 right first");
        chk(rd_cnt - c == 1 && last_rd == 12'd50, "R8",
            $sformatf("reads actual=%0d@%0d expected=1@50", rd_cnt - c, last_rd));
        expect_issue(lop(51), ladr(51), "R8 next left");
    endtask

    task automatic t_range();
        int c;
        do_jump(999, 0);
        expect_issue(lop(999), ladr(999), "R9 last word left");
        expect_issue(rop(999), radr(999), "R9 last word right");
        c = rd_cnt;
        repeat (10) @(negedge clk);
        chk(fetch_err == 1, "R9", $sformatf("fetch_err actual=%0b expected=1", fetch_err));
        chk(iss_valid == 0, "R9", $sformatf("iss_valid actual=%0b expected=0", iss_valid));
        chk(rd_cnt == c && !oob_seen, "R9", $sformatf("oob reads actual=%0d expected=0", rd_cnt - c));
        do_jump(4, 1);
        expect_issue(rop(4), radr(4), "R9 resume");
        chk(fetch_err == 1, "R9", $sformatf("sticky fetch_err actual=%0b expected=1", fetch_err));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_stall();
        t_jump_left_flush();
        t_jump_right();
        t_range();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule